// File: doc/BRIEF.md
# Beam-Synchronised Display List Sequencer

This block is a small coprocessor that walks a byte-coded instruction list held in a local memory. It executes the list in step with the position of a video beam, given as a 9-bit raster line and a 6-bit cycle within the line. The list can write bytes into a video register space or an internal register space, and it can stall until the beam reaches a position. It can also test whether that position has already passed and skip the next instruction, branch relative to itself, manage two 8-bit loop counters, raise an interrupt pulse and terminate.

The list memory is read through a combinational port: `mem_addr_o` selects a byte and `mem_data_i` returns it in the same cycle. A controlling agent sets the start address and raises `run_i`. While `run_i` is low the sequencer sits idle. Each rising of `run_i` after idle restarts the list from `start_addr_i`, with the masks set to all ones and the delays, counters and skip state cleared. Instruction encodings: `0xxxxxxx` is a two-byte WAIT. In its first byte, bits 6:1 are the cycle and bit 0 is line bit 8; the second byte is line bits 7:0. `11rrrrrr dd` writes `dd` to video register `r`. `100xrrrr dd` writes `dd` to internal register `0x40+r`. `A3 oo` branches by signed `oo` from the address after the instruction. `B0 hh` sets the cycle delay to `hh[5:0]` and the line delay to `hh[7:6]`. `B8/B9 ll` sets the 9-bit line delay, with bit 8 taken from opcode bit 0. `B4 mm` sets the cycle mask to `mm[5:0]`. `BC/BD ll` sets the 9-bit line mask. `B2 vv` and `B3 vv` load counters A and B. The one-byte opcodes are `A0` (decrement A), `A1` (decrement B), `A2` (interrupt), `A4` (wait for bad line), `A6` (skip test) and `A7` (no operation). Every other byte from `A0` to `BF` is a one-byte no-operation.

The controller has six states: IDLE, OPC (fetch opcode), ARG (fetch operand and execute), BEAM (beam wait), BADL (bad-line wait) and HALT. The transitions are as follows. Any state goes to IDLE when `run_i` is low. IDLE goes to OPC when `run_i` is high. OPC goes to ARG for a two-byte opcode and to BADL for `A4`; otherwise it stays in OPC. OPC also stays in OPC while it steps over a skipped instruction. ARG goes to HALT on the end marker, to BEAM on an unreached WAIT that is not armed as a test, and to OPC otherwise. BEAM goes to OPC once the position is reached. BADL goes to OPC on `badline_i`. HALT stays in HALT until `run_i` falls.

Top module: `dlseq_top`

## Requirements
- R1: After reset, and whenever `run_i` is low, no register write and no interrupt is produced. One clock after `run_i` is seen high in IDLE, `mem_addr_o` equals `start_addr_i`, and the fetch continues from there.
- R2: Opcode `11rrrrrr` followed by data `dd` pulses `reg_wr_o` for one clock, with `reg_addr_o = {1'b0, rrrrrr}` and `reg_data_o = dd`. The pulse comes one clock after the operand fetch.
- R3: Opcode `100xrrrr` followed by `dd` writes `dd` to `reg_addr_o = 0x40 + rrrr`; bit x is ignored.
- R4: A WAIT forms a position from the beam line AND line-mask plus line-delay, and the beam cycle AND cycle-mask plus cycle-delay, without wrap. It stalls until that position is lexicographically (line first) at or beyond the target, and `mem_addr_o` holds still while it stalls.
- R5: A WAIT with line `0x1FF` and cycle `0x3F` sets `halted_o`, which stays high with no further fetch or writes until `run_i` falls and rises again.
- R6: `A3 oo` moves execution to the address after the branch plus the sign-extended `oo`, both forward and backward.
- R7: After `A6`, the next WAIT becomes a test and never stalls. If its position is already reached, the following instruction (one or two bytes) is stepped over without effect. Non-WAIT instructions between `A6` and the WAIT execute normally.
- R8: `B2 vv` and `B3 vv` load counters A and B (`cnt_a_o`, `cnt_b_o`). `A0` and `A1` decrement them modulo 256.
- R9: `A2` produces a one-clock `irq_o` pulse one clock after the opcode fetch.
- R10: `B4`, `BC/BD`, `B0` and `B8/B9` set the cycle mask, line mask, cycle delay (with line delay from bits 7:6) and line delay that later WAITs use.
- R11: `A4` stalls with `mem_addr_o` unchanged until `badline_i` is seen high.
- R12: Undefined opcodes in the range `A0`–`BF` advance by one byte and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Sequencer enable; a low-to-high passage through IDLE restarts the list |
| start_addr_i | input | ADDR_W | First list address used on each start |
| beam_line_i | input | 9 | Current raster line |
| beam_cyc_i | input | 6 | Current cycle within the line |
| badline_i | input | 1 | Bad-line indication used by the `A4` wait |
| mem_addr_o | output | ADDR_W | List memory read address |
| mem_data_i | input | 8 | List memory read data, same cycle |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | 7 | Register address: 0x00–0x3F video, 0x40–0x4F internal |
| reg_data_o | output | 8 | Register write data |
| irq_o | output | 1 | Interrupt pulse |
| halted_o | output | 1 | High in HALT |
| cnt_a_o | output | 8 | Loop counter A |
| cnt_b_o | output | 8 | Loop counter B |

## Verification
The beam comparison and the skip logic meet in the same ARG cycle. When a SKIP-armed WAIT is executed, the beam test decides in that cycle whether the next instruction is stepped over instead of whether to stall. The bench provokes both outcomes: one armed WAIT targets a line the beam has already passed, and another targets a line far ahead. In the second run, a register write sits between the SKIP and its WAIT. The result is judged from the exact sequence of register writes and the interrupt count, and a cycle-by-cycle reference model also checks that the fetch address never pauses on an armed WAIT.

// File: rtl/dlseq_pkg.sv
package dlseq_pkg;
    localparam int LINE_W = 9;
    localparam int CYC_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ARG,
        ST_BEAM,
        ST_BADL,
        ST_HALT
    } seq_state_e;

    typedef enum logic [3:0] {
        K_NOP, K_WAIT, K_WVID, K_WINT, K_BRA, K_DLYH, K_DLYV, K_MSKH,
        K_MSKV, K_SETA, K_SETB, K_DECA, K_DECB, K_IRQ, K_BAD, K_SKIP
    } op_kind_e;
endpackage

// File: rtl/dlseq_decode.sv
module dlseq_decode
    import dlseq_pkg::*;
(
    input  logic [7:0] opc_i,
    output op_kind_e   kind_o,
    output logic       two_o
);
    always_comb begin
        if (!opc_i[7])                 kind_o = K_WAIT;
        else if (opc_i[7:6] == 2'b11)  kind_o = K_WVID;
        else if (opc_i[7:5] == 3'b100) kind_o = K_WINT;
        else begin
            case (opc_i)
                8'hA0:        kind_o = K_DECA;
                8'hA1:        kind_o = K_DECB;
                8'hA2:        kind_o = K_IRQ;
                8'hA3:        kind_o = K_BRA;
                8'hA4:        kind_o = K_BAD;
                8'hA6:        kind_o = K_SKIP;
                8'hB0:        kind_o = K_DLYH;
                8'hB2:        kind_o = K_SETA;
                8'hB3:        kind_o = K_SETB;
                8'hB4:        kind_o = K_MSKH;
                8'hB8, 8'hB9: kind_o = K_DLYV;
                8'hBC, 8'hBD: kind_o = K_MSKV;
                default:      kind_o = K_NOP;
            endcase
        end
    end

    always_comb begin
        case (kind_o)
            K_WAIT, K_WVID, K_WINT, K_BRA, K_DLYH,
            K_DLYV, K_MSKH, K_MSKV, K_SETA, K_SETB: two_o = 1'b1;
            default:                                two_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dlseq_beamcmp.sv
module dlseq_beamcmp
    import dlseq_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic [LINE_W-1:0] mask_l_i,
    input  logic [CYC_W-1:0]  mask_c_i,
    input  logic [LINE_W-1:0] dly_l_i,
    input  logic [CYC_W-1:0]  dly_c_i,
    input  logic [LINE_W-1:0] tgt_l_i,
    input  logic [CYC_W-1:0]  tgt_c_i,
    output logic              reached_o
);
    logic [LINE_W:0] pos_l;
    logic [CYC_W:0]  pos_c;

    always_comb begin
        pos_l     = {1'b0, line_i & mask_l_i} + {1'b0, dly_l_i};
        pos_c     = {1'b0, cyc_i & mask_c_i} + {1'b0, dly_c_i};
        reached_o = (pos_l > {1'b0, tgt_l_i}) ||
                    ((pos_l == {1'b0, tgt_l_i}) && (pos_c >= {1'b0, tgt_c_i}));
    end
endmodule

// File: rtl/dlseq_top.sv
module dlseq_top
    import dlseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [8:0]        beam_line_i,
    input  logic [5:0]        beam_cyc_i,
    input  logic              badline_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic              reg_wr_o,
    output logic [6:0]        reg_addr_o,
    output logic [7:0]        reg_data_o,
    output logic              irq_o,
    output logic              halted_o,
    output logic [7:0]        cnt_a_o,
    output logic [7:0]        cnt_b_o
);
    localparam int SEXT_W = ADDR_W - 8;

    seq_state_e        st_q, st_d;
    logic [ADDR_W-1:0] pc_q;
    logic [7:0]        op_q;
    logic              skip_arm_q, skip_next_q;
    logic [LINE_W-1:0] mask_l_q, dly_l_q, tgt_l_q;
    logic [CYC_W-1:0]  mask_c_q, dly_c_q, tgt_c_q;
    logic [7:0]        cnt_a_q, cnt_b_q;

    logic [7:0]        dec_byte;
    op_kind_e          kind;
    logic              two;
    logic [LINE_W-1:0] wait_l, cmp_l;
    logic [CYC_W-1:0]  wait_c, cmp_c;
    logic              is_end, reached;
    logic [ADDR_W-1:0] br_off;

    assign dec_byte = (st_q == ST_OPC) ? mem_data_i : op_q;
    assign wait_l   = {op_q[0], mem_data_i};
    assign wait_c   = op_q[6:1];
    assign is_end   = (wait_l == '1) && (wait_c == '1);
    assign cmp_l    = (st_q == ST_ARG) ? wait_l : tgt_l_q;
    assign cmp_c    = (st_q == ST_ARG) ? wait_c : tgt_c_q;
    assign br_off   = {{SEXT_W{mem_data_i[7]}}, mem_data_i};

    dlseq_decode u_dec (
        .opc_i  (dec_byte),
        .kind_o (kind),
        .two_o  (two)
    );

    dlseq_beamcmp u_cmp (
        .line_i    (beam_line_i),
        .cyc_i     (beam_cyc_i),
        .mask_l_i  (mask_l_q),
        .mask_c_i  (mask_c_q),
        .dly_l_i   (dly_l_q),
        .dly_c_i   (dly_c_q),
        .tgt_l_i   (cmp_l),
        .tgt_c_i   (cmp_c),
        .reached_o (reached)
    );

    // next state
    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_OPC;
                ST_OPC: begin
                    if (!skip_next_q) begin
                        if (kind == K_BAD) st_d = ST_BADL;
                        else if (two)      st_d = ST_ARG;
                    end
                end
                ST_ARG: begin
                    if (kind == K_WAIT && is_end)                         st_d = ST_HALT;
                    else if (kind == K_WAIT && !skip_arm_q && !reached)   st_d = ST_BEAM;
                    else                                                  st_d = ST_OPC;
                end
                ST_BEAM: if (reached)   st_d = ST_OPC;
                ST_BADL: if (badline_i) st_d = ST_OPC;
                ST_HALT: st_d = ST_HALT;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q        <= '0;
            op_q        <= '0;
            skip_arm_q  <= 1'b0;
            skip_next_q <= 1'b0;
            mask_l_q    <= '1;
            mask_c_q    <= '1;
            dly_l_q     <= '0;
            dly_c_q     <= '0;
            tgt_l_q     <= '0;
            tgt_c_q     <= '0;
            cnt_a_q     <= '0;
            cnt_b_q     <= '0;
        end else if (run_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    pc_q        <= start_addr_i;
                    skip_arm_q  <= 1'b0;
                    skip_next_q <= 1'b0;
                    mask_l_q    <= '1;
                    mask_c_q    <= '1;
                    dly_l_q     <= '0;
                    dly_c_q     <= '0;
                    cnt_a_q     <= '0;
                    cnt_b_q     <= '0;
                end
                ST_OPC: begin
                    if (skip_next_q) begin
                        skip_next_q <= 1'b0;
                        pc_q        <= pc_q + ADDR_W'(two ? 2 : 1);
                    end else begin
                        pc_q <= pc_q + ADDR_W'(1);
                        op_q <= mem_data_i;
                        case (kind)
                            K_DECA:  cnt_a_q    <= cnt_a_q - 8'd1;
                            K_DECB:  cnt_b_q    <= cnt_b_q - 8'd1;
                            K_SKIP:  skip_arm_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_ARG: begin
                    pc_q <= pc_q + ADDR_W'(1);
                    case (kind)
                        K_WAIT: begin
                            if (!is_end) begin
                                if (skip_arm_q) begin
                                    skip_arm_q  <= 1'b0;
                                    skip_next_q <= reached;
                                end else if (!reached) begin
                                    tgt_l_q <= wait_l;
                                    tgt_c_q <= wait_c;
                                end
                            end
                        end
                        K_BRA:  pc_q     <= pc_q + ADDR_W'(1) + br_off;
                        K_DLYH: begin
                            dly_c_q <= mem_data_i[5:0];
                            dly_l_q <= {7'd0, mem_data_i[7:6]};
                        end
                        K_DLYV: dly_l_q  <= wait_l;
                        K_MSKH: mask_c_q <= mem_data_i[5:0];
                        K_MSKV: mask_l_q <= wait_l;
                        K_SETA: cnt_a_q  <= mem_data_i;
                        K_SETB: cnt_b_q  <= mem_data_i;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_wr_o   <= 1'b0;
            reg_addr_o <= '0;
            reg_data_o <= '0;
            irq_o      <= 1'b0;
        end else begin
            reg_wr_o <= run_i && (st_q == ST_ARG) && (kind == K_WVID || kind == K_WINT);
            irq_o    <= run_i && (st_q == ST_OPC) && !skip_next_q && (kind == K_IRQ);
            if (run_i && (st_q == ST_ARG) && (kind == K_WVID || kind == K_WINT)) begin
                reg_addr_o <= (kind == K_WVID) ? {1'b0, op_q[5:0]} : {3'b100, op_q[3:0]};
                reg_data_o <= mem_data_i;
            end
        end
    end

    assign mem_addr_o = pc_q;
    assign halted_o   = (st_q == ST_HALT);
    assign cnt_a_o    = cnt_a_q;
    assign cnt_b_o    = cnt_b_q;
endmodule

// File: rtl/dlseq_checker.sv
module dlseq_checker
    import dlseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              badline_i,
    input logic              halted_o,
    input logic              reg_wr_o,
    input logic [6:0]        reg_addr_o,
    input logic              irq_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input seq_state_e        state_i
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!reg_wr_o && !irq_o)); // R1

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && run_i) |=> halted_o); // R5

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (!reg_wr_o && !irq_o)); // R5

    AST_INT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && reg_addr_o[6]) |-> (reg_addr_o[5:4] == 2'b00)); // R3

    AST_BEAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_BEAM) |=> $stable(mem_addr_o)); // R4

    AST_BADL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_BADL && !badline_i) |=> $stable(mem_addr_o)); // R11
endmodule

bind dlseq_top dlseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .badline_i  (badline_i),
    .halted_o   (halted_o),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .irq_o      (irq_o),
    .mem_addr_o (mem_addr_o),
    .state_i    (st_q)
);

// File: tb/dlseq_top_bench.sv
module dlseq_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] start_addr = '0;
    logic [8:0]  line = '0;
    logic [5:0]  cyc = '0;
    logic        badl;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        wr, irq, halted;
    logic [6:0]  waddr;
    logic [7:0]  wdata, cnt_a, cnt_b;

    logic [7:0]  mem [0:255];

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    int irq_cnt = 0;
    int log_a[$], log_d[$], log_l[$], log_c[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign badl     = (line[2:0] == 3'd3) && (cyc == 6'd14);
    assign mem_data = mem[mem_addr[7:0]];

    dlseq_top u_dlseq_top (
        .clk(clk), .rst_n(rst_n), .run_i(run), .start_addr_i(start_addr),
        .beam_line_i(line), .beam_cyc_i(cyc), .badline_i(badl),
        .mem_addr_o(mem_addr), .mem_data_i(mem_data),
        .reg_wr_o(wr), .reg_addr_o(waddr), .reg_data_o(wdata),
        .irq_o(irq), .halted_o(halted), .cnt_a_o(cnt_a), .cnt_b_o(cnt_b)
    );

    // ---------------- behavioural reference model ----------------
    int          ms = 0;          // 0 idle 1 opc 2 arg 3 beam 4 badl 5 halt
    logic [15:0] mpc = '0;
    logic [7:0]  mop = '0;
    bit          mskf = 0, mskn = 0;
    logic [8:0]  mml = 9'h1FF, mdl = '0, mtl = '0;
    logic [5:0]  mmc = 6'h3F, mdc = '0, mtc = '0;
    logic [7:0]  mca = '0, mcb = '0;
    bit          mwr = 0, mirq = 0;
    logic [6:0]  mwa = '0;
    logic [7:0]  mwd = '0;

    function automatic bit reach(logic [8:0] tl, logic [5:0] tc);
        int pl, pc;
        pl = int'(line & mml) + int'(mdl);
        pc = int'(cyc & mmc) + int'(mdc);
        return (pl > int'(tl)) || (pl == int'(tl) && pc >= int'(tc));
    endfunction

    function automatic int oplen(logic [7:0] b);
        if (b < 8'hA0 || b >= 8'hC0) return 2;
        if (b == 8'hA3 || b == 8'hB0 || b == 8'hB2 || b == 8'hB3 || b == 8'hB4 ||
            b == 8'hB8 || b == 8'hB9 || b == 8'hBC || b == 8'hBD) return 2;
        return 1;
    endfunction

    task automatic model_step();
        logic [7:0] b;
        logic [8:0] tl;
        logic [5:0] tc;
        bit nwr = 0, nirq = 0;
        if (!run) ms = 0;
        else case (ms)
            0: begin
                mpc = start_addr; mml = 9'h1FF; mmc = 6'h3F; mdl = 0; mdc = 0;
                mskf = 0; mskn = 0; mca = 0; mcb = 0; ms = 1;
            end
            1: begin
                b = mem[mpc[7:0]];
                if (mskn) begin
                    mskn = 0; mpc = mpc + 16'(oplen(b));
                end else begin
                    mpc = mpc + 16'd1; mop = b;
                    if (b == 8'hA0) mca = mca - 8'd1;
                    if (b == 8'hA1) mcb = mcb - 8'd1;
                    if (b == 8'hA2) nirq = 1;
                    if (b == 8'hA6) mskf = 1;
                    if (b == 8'hA4) ms = 4;
                    else if (oplen(b) == 2) ms = 2;
                end
            end
            2: begin
                b = mem[mpc[7:0]];
                mpc = mpc + 16'd1;
                tl = {mop[0], b};
                tc = mop[6:1];
                ms = 1;
                if (mop < 8'h80) begin
                    if (tl == 9'h1FF && tc == 6'h3F) ms = 5;
                    else if (mskf) begin
                        mskf = 0;
                        if (reach(tl, tc)) mskn = 1;
                    end else if (!reach(tl, tc)) begin
                        mtl = tl; mtc = tc; ms = 3;
                    end
                end else if (mop >= 8'hC0) begin
                    nwr = 1; mwa = {1'b0, mop[5:0]}; mwd = b;
                end else if (mop < 8'hA0) begin
                    nwr = 1; mwa = 7'h40 + {3'b0, mop[3:0]}; mwd = b;
                end else begin
                    case (mop)
                        8'hA3: mpc = mpc + {{8{b[7]}}, b};
                        8'hB0: begin mdc = b[5:0]; mdl = {7'd0, b[7:6]}; end
                        8'hB2: mca = b;
                        8'hB3: mcb = b;
                        8'hB4: mmc = b[5:0];
                        8'hB8, 8'hB9: mdl = tl;
                        8'hBC, 8'hBD: mml = tl;
                        default: ;
                    endcase
                end
            end
            3: if (reach(mtl, mtc)) ms = 1;
            4: if (badl) ms = 1;
            default: ;
        endcase
        mwr = nwr;
        mirq = nirq;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mpc = '0; mwr = 0; mirq = 0; mca = 0; mcb = 0;
        end else begin
            model_step();
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison, logging, then beam advance
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ok = 1;
            total++;
            if (mem_addr !== mpc) begin ok = 0; $display("FAIL R1 fetch address: actual=%0h expected=%0h", mem_addr, mpc); end
            if (halted !== (ms == 5)) begin ok = 0; $display("FAIL R5 halted: actual=%0d expected=%0d", halted, ms == 5); end
            if (irq !== mirq) begin ok = 0; $display("FAIL R9 irq: actual=%0d expected=%0d", irq, mirq); end
            if (wr !== mwr) begin ok = 0; $display("FAIL R2 write strobe: actual=%0d expected=%0d", wr, mwr); end
            if (mwr && (waddr !== mwa || wdata !== mwd)) begin
                ok = 0; $display("FAIL R3 write addr/data: actual=%0h/%0h expected=%0h/%0h", waddr, wdata, mwa, mwd);
            end
            if (cnt_a !== mca || cnt_b !== mcb) begin
                ok = 0; $display("FAIL R8 counters: actual=%0h/%0h expected=%0h/%0h", cnt_a, cnt_b, mca, mcb);
            end
            if (!ok) bad++;
            if (wr) begin
                log_a.push_back(int'(waddr)); log_d.push_back(int'(wdata));
                log_l.push_back(int'(line));  log_c.push_back(int'(cyc));
            end
            if (irq) irq_cnt++;
        end
        if (cyc == 6'd62) begin
            cyc <= '0;
            line <= (line == 9'd311) ? '0 : line + 9'd1;
        end else begin
            cyc <= cyc + 6'd1;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            total++; bad++;
            $display("FAIL R5 watchdog: actual=%0d expected<=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic wait_halt(string tag);
        int n = 0;
        while (!halted && n < 20000) begin @(negedge clk); n++; end
        chk(halted == 1'b1, tag, int'(halted), 1);
    endtask

    task automatic clear_logs();
        log_a.delete(); log_d.delete(); log_l.delete(); log_c.delete();
        irq_cnt = 0;
    endtask

    logic [7:0] prog1 [$] = '{
        8'hB2,8'h03, 8'hB3,8'h05, 8'hC5,8'h11, 8'h8A,8'h22, 8'hA0, 8'hA2, 8'hA7, 8'hAF,
        8'h14,8'h02, 8'hC1,8'h33, 8'hA6, 8'h00,8'h01, 8'hC2,8'h44, 8'hA6, 8'h00,8'h64,
        8'hC3,8'h55, 8'hBC,8'h00, 8'h64,8'h00, 8'hC4,8'h66, 8'hB0,8'h05, 8'h78,8'h00,
        8'hBD,8'hFF, 8'hB0,8'h00, 8'hB8,8'h03, 8'h00,8'h0A, 8'hB8,8'h00, 8'hB4,8'h00,
        8'h00,8'h0C, 8'hB4,8'h3F, 8'hA1, 8'hA4, 8'h9F,8'h77, 8'hA3,8'h04, 8'h7F,8'hFF,
        8'hC9,8'h99, 8'hC8,8'h88, 8'hA3,8'hF8};
    logic [7:0] prog2 [$] = '{
        8'hA1, 8'hA6, 8'hC6,8'h12, 8'h00,8'h00, 8'hC6,8'h13, 8'hC6,8'h14,
        8'hA6, 8'h00,8'h00, 8'hA2, 8'hA0, 8'h7F,8'hFF};

    int exp1_a[7] = '{'h05, 'h4A, 'h01, 'h03, 'h04, 'h4F, 'h08};
    int exp1_d[7] = '{'h11, 'h22, 'h33, 'h55, 'h66, 'h77, 'h88};

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        foreach (prog1[i]) mem[16 + i] = prog1[i];
        foreach (prog2[i]) mem[90 + i] = prog2[i];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_addr == 16'd0 && !wr && !irq && !halted, "R1 reset state", int'(mem_addr), 0);
        repeat (5) @(negedge clk);
        chk(!wr && !irq && mem_addr == 16'd0, "R1 idle while run low", int'(wr), 0);

        // run 1
        clear_logs();
        start_addr = 16'd16;
        run = 1'b1;
        @(negedge clk);
        chk(mem_addr == 16'd16, "R1 start address", int'(mem_addr), 16);
        wait_halt("R5 end marker halts run 1");
        chk(log_a.size() == 7, "R6 R7 R12 write count run 1", log_a.size(), 7);
        for (int i = 0; i < 7 && i < log_a.size(); i++) begin
            chk(log_a[i] == exp1_a[i], "R2 R3 write address", log_a[i], exp1_a[i]);
            chk(log_d[i] == exp1_d[i], "R2 R3 write data", log_d[i], exp1_d[i]);
        end
        if (log_a.size() == 7) begin
            chk(log_l[2] == 2 && log_c[2] >= 10 && log_c[2] <= 14, "R4 wait line 2 cycle 10", log_l[2] * 64 + log_c[2], 2 * 64 + 12);
            chk(log_c[4] >= 50 && log_c[4] <= 55, "R10 masked line wait cycle 50", log_c[4], 52);
            chk(log_l[5] == 19, "R11 bad line wait", log_l[5], 19);
        end
        chk(irq_cnt == 1, "R9 irq count run 1", irq_cnt, 1);
        chk(cnt_a == 8'h02 && cnt_b == 8'h04, "R8 counters run 1", {cnt_a, cnt_b}, 16'h0204);
        repeat (50) @(negedge clk);
        chk(halted && log_a.size() == 7, "R5 stays halted", int'(halted), 1);

        // run 2
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk(!halted, "R5 halt released by run low", int'(halted), 0);
        clear_logs();
        start_addr = 16'd90;
        run = 1'b1;
        wait_halt("R5 end marker halts run 2");
        chk(log_a.size() == 2, "R7 write count run 2", log_a.size(), 2);
        if (log_a.size() == 2) begin
            chk(log_a[0] == 'h06 && log_d[0] == 'h12, "R7 write before armed wait", log_d[0], 'h12);
            chk(log_a[1] == 'h06 && log_d[1] == 'h14, "R7 skipped write", log_d[1], 'h14);
        end
        chk(irq_cnt == 0, "R7 skipped one-byte irq", irq_cnt, 0);
        chk(cnt_a == 8'hFF && cnt_b == 8'hFF, "R8 decrement wraps", {cnt_a, cnt_b}, 16'hFFFF);

        // run 3: abort mid-list
        run = 1'b0;
        repeat (2) @(negedge clk);
        start_addr = 16'd16;
        run = 1'b1;
        repeat (40) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        clear_logs();
        repeat (30) @(negedge clk);
        chk(log_a.size() == 0 && irq_cnt == 0, "R1 quiet after run drop", log_a.size(), 0);
        chk(!halted, "R1 idle not halted", int'(halted), 0);

        finish_run();
    end
endmodule